// File: doc/BRIEF.md
# Write-Only Serial Register Target

This block is a target on a two-wire serial bus (I2C) that only ever accepts writes. It sits behind a pair of bus pins, samples SCL and SDA with a system clock that runs at least sixteen times faster than the bus, and turns each written byte into a one-cycle write strobe for a small register bank next to it. It acknowledges bytes by enabling an open-drain pull-down on SDA. It never drives SDA high and never holds SCL low.

A transfer begins with a START. The first byte carries a fixed 7-bit device address and a direction bit, and the second byte loads an 8-bit register pointer. Every byte after that is data. Each data byte is written to the address the pointer holds, and then the pointer advances by one, so a burst fills consecutive registers. The target does not answer a read request, a foreign address, or bus traffic outside a transfer it has accepted.

Top module: `i2cw_target`

## Requirements
- R1: A first byte of 1101011 (bits 7..1) with bit 0 equal to 0 is acknowledged. The target holds SDA low (sda_oe = 1) for the whole ninth SCL pulse after that byte.
- R2: A first byte with any other address in bits 7..1 gets no acknowledge. No byte is acknowledged and no write strobe appears until the next START.
- R3: A first byte of 1101011 with bit 0 equal to 1 (a read request) gets no acknowledge, and the rest of that transfer is ignored.
- R4: The second byte of an accepted transfer is acknowledged and loads the register pointer. It produces no write strobe.
- R5: Each later byte is received most significant bit first and acknowledged. It produces exactly one system-clock pulse on wr_en, with wr_addr equal to the pointer and wr_data equal to the byte.
- R6: After each data byte the pointer advances by one and wraps from 0xFF to 0x00.
- R7: A START in any state, including one in the middle of a byte, restarts address reception. A STOP ends the transfer, and bits clocked after it are ignored until a START.
- R8: sda_oe changes only while SCL is low. It stays constant over any interval in which SCL stays high.
- R9: Reset leaves sda_oe at 0 and wr_en at 0.
- R10: A write strobe is issued in the same cycle that the acknowledge for its data byte begins, so wr_en implies sda_oe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired level) |
| sda_oe | output | 1 | 1 enables the open-drain pull-down on SDA |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register address for the strobe |
| wr_data | output | 8 | Data byte for the strobe |

## Verification
Three things land together on the SCL falling edge that ends a data byte: the write strobe, the step of the pointer, and the start of the acknowledge drive. A burst that crosses 0xFF provokes all three in the same cycle and also tests the wrap. The strobe must carry the pre-increment address while the next byte lands at the incremented one. A START can also arrive while the byte counter is partly filled. A transfer aborted after four bits and restarted shows whether the START wins over the stale bit count, which is judged by whether the restarted write reaches the right register.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    localparam int REG_AW = 8;
    localparam int REG_DW = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_IGN
    } bus_st_t;

    typedef enum logic [1:0] {
        K_DEV,
        K_REG,
        K_DATA
    } byte_kind_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic              en;
        logic [REG_AW-1:0] addr;
        logic [REG_DW-1:0] data;
    } wr_req_t;

    function automatic logic dev_write_hit(input logic [7:0] b, input logic [6:0] dev);
        return (b[7:1] == dev) && !b[0];
    endfunction

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync
    import i2cw_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] now_v;
    logic [NLINES-1:0] prv_v;

    assign raw = {scl_in, sda_in};

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic [STAGES-1:0] chain_q;
        logic              prev_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= '1;
                prev_q  <= 1'b1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], raw[i]};
                prev_q  <= chain_q[STAGES-1];
            end
        end
        assign now_v[i] = chain_q[STAGES-1];
        assign prv_v[i] = prev_q;
    end

    always_comb begin
        ev.scl      = now_v[1];
        ev.sda      = now_v[0];
        ev.scl_rise = now_v[1] & ~prv_v[1];
        ev.scl_fall = ~now_v[1] & prv_v[1];
        ev.start    = now_v[1] & prv_v[1] & ~now_v[0] & prv_v[0];
        ev.stop     = now_v[1] & prv_v[1] & now_v[0] & ~prv_v[0];
    end

endmodule

// File: rtl/i2cw_rx.sv
module i2cw_rx
    import i2cw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic       rx_en,
    input  logic       rx_clr,
    output logic [7:0] byte_o,
    output logic       full_o
);
    logic [7:0] shift_q;
    logic [3:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (rx_clr) begin
            cnt_q <= '0;
        end else if (rx_en && ev.scl_rise && (cnt_q != 4'd8)) begin
            shift_q <= {shift_q[6:0], ev.sda};
            cnt_q   <= cnt_q + 4'd1;
        end
    end

    assign byte_o = shift_q;
    assign full_o = (cnt_q == 4'd8);

endmodule

// File: rtl/i2cw_ctrl.sv
module i2cw_ctrl
    import i2cw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1101011
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic [7:0] byte_i,
    input  logic       full_i,
    output logic       rx_en,
    output logic       rx_clr,
    output logic       sda_oe,
    output wr_req_t    wr
);
    bus_st_t           st_q;
    byte_kind_t        kind_q;
    logic [REG_AW-1:0] ptr_q;
    logic              done;

    assign done   = (st_q == ST_RX) && full_i && ev.scl_fall;
    assign rx_en  = (st_q == ST_RX);
    assign rx_clr = ev.start | ev.stop | done;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            kind_q <= K_DEV;
            ptr_q  <= '0;
            sda_oe <= 1'b0;
            wr     <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.start) begin
                st_q   <= ST_RX;
                kind_q <= K_DEV;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                st_q   <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (st_q)
                    ST_RX: if (done) begin
                        unique case (kind_q)
                            K_DEV: begin
                                if (dev_write_hit(byte_i, DEV_ADDR)) begin
                                    sda_oe <= 1'b1;
                                    st_q   <= ST_ACK;
                                    kind_q <= K_REG;
                                end else begin
                                    st_q <= ST_IGN;
                                end
                            end
                            K_REG: begin
                                ptr_q  <= byte_i;
                                sda_oe <= 1'b1;
                                st_q   <= ST_ACK;
                                kind_q <= K_DATA;
                            end
                            default: begin
                                wr.en   <= 1'b1;
                                wr.addr <= ptr_q;
                                wr.data <= byte_i;
                                ptr_q   <= ptr_q + 1'b1;
                                sda_oe  <= 1'b1;
                                st_q    <= ST_ACK;
                            end
                        endcase
                    end
                    ST_ACK: if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        st_q   <= ST_RX;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2cw_target.sv
module i2cw_target
    import i2cw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1101011,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [REG_DW-1:0] wr_data
);
    bus_ev_t    bus_ev;
    logic [7:0] rx_byte;
    logic       rx_full;
    logic       rx_en;
    logic       rx_clr;
    wr_req_t    wr;

    i2cw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (bus_ev)
    );

    i2cw_rx u_rx (
        .clk    (clk),
        .rst    (rst),
        .ev     (bus_ev),
        .rx_en  (rx_en),
        .rx_clr (rx_clr),
        .byte_o (rx_byte),
        .full_o (rx_full)
    );

    i2cw_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .ev     (bus_ev),
        .byte_i (rx_byte),
        .full_i (rx_full),
        .rx_en  (rx_en),
        .rx_clr (rx_clr),
        .sda_oe (sda_oe),
        .wr     (wr)
    );

    assign wr_en   = wr.en;
    assign wr_addr = wr.addr;
    assign wr_data = wr.data;

endmodule

// File: rtl/i2cw_chk.sv
module i2cw_chk (
    input logic clk,
    input logic rst,
    input logic scl_in,
    input logic sda_oe,
    input logic wr_en
);
    // R8
    oe_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_in && $past(scl_in)) |-> $stable(sda_oe));

    // R8
    oe_rise_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_in);

    // R10
    strobe_ack_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> sda_oe);

    // R5
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!sda_oe && !wr_en));
endmodule

bind i2cw_target i2cw_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .scl_in (scl_in),
    .sda_oe (sda_oe),
    .wr_en  (wr_en)
);

// File: tb/tb_i2cw_target.sv
module tb_i2cw_target;
    localparam int CLK_NS = 10;
    localparam int HALF   = 20;
    localparam int QTR    = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic       wr_en;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    int exp_a[$];
    int exp_d[$];

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_NS/2) clk = ~clk;

    i2cw_target dut (
        .clk     (clk),
        .rst     (rst),
        .scl_in  (scl_m),
        .sda_in  (sda_line),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // behavioural reference: expected writes in a queue, bus levels tracked per clock
    logic prev_scl = 1'b1;
    logic prev_oe  = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                chk(sda_oe, "R10", "ack with strobe", sda_oe, 1);
                if (exp_a.size() == 0) begin
                    chk(0, "R2/R3/R7", "unexpected strobe addr", wr_addr, -1);
                end else begin
                    chk(wr_addr == exp_a[0][7:0], "R6", "strobe addr", wr_addr, exp_a[0]);
                    chk(wr_data == exp_d[0][7:0], "R5", "strobe data", wr_data, exp_d[0]);
                    void'(exp_a.pop_front());
                    void'(exp_d.pop_front());
                end
            end
            if (prev_scl && scl_m && (sda_oe != prev_oe))
                chk(0, "R8", "sda_oe moved with SCL high", sda_oe, prev_oe);
        end
        prev_scl = scl_m;
        prev_oe  = sda_oe;
    end

    task automatic tk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_c();
        sda_m = 1'b1; tk(QTR);
        scl_m = 1'b1; tk(QTR);
        sda_m = 1'b0; tk(QTR);
        scl_m = 1'b0; tk(QTR);
    endtask

    task automatic stop_c();
        scl_m = 1'b0; tk(QTR);
        sda_m = 1'b0; tk(QTR);
        scl_m = 1'b1; tk(QTR);
        sda_m = 1'b1; tk(QTR);
    endtask

    task automatic bit_c(input logic b);
        scl_m = 1'b0; tk(QTR);
        sda_m = b;    tk(QTR);
        scl_m = 1'b1; tk(HALF);
        scl_m = 1'b0; tk(QTR);
    endtask

    task automatic byte_c(input logic [7:0] v, input bit exp_ack, input string req);
        bit got;
        for (int i = 7; i >= 0; i--) bit_c(v[i]);
        sda_m = 1'b1; tk(QTR);
        scl_m = 1'b1; tk(QTR);
        got = !sda_line;
        tk(QTR);
        scl_m = 1'b0; tk(QTR);
        chk(got == exp_ack, req, "ack on ninth pulse", got, exp_ack);
    endtask

    task automatic push_w(input int a, input int d);
        exp_a.push_back(a);
        exp_d.push_back(d);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog expired: actual 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        tk(5);
        chk(sda_oe == 1'b0 && wr_en == 1'b0, "R9", "outputs in reset", {sda_oe, wr_en}, 0);
        rst = 1'b0;
        tk(20);
        chk(sda_oe == 1'b0 && wr_en == 1'b0, "R9", "outputs after reset", {sda_oe, wr_en}, 0);

        // R1 R4 R5: plain burst of two
        start_c();
        byte_c(8'hD6, 1, "R1");
        byte_c(8'h10, 1, "R4");
        push_w(8'h10, 8'hA5); byte_c(8'hA5, 1, "R5");
        push_w(8'h11, 8'h3C); byte_c(8'h3C, 1, "R5");
        stop_c();

        // R2: foreign address, later bytes ignored
        start_c();
        byte_c(8'hD4, 0, "R2");
        byte_c(8'h22, 0, "R2");
        byte_c(8'h5A, 0, "R2");
        stop_c();

        // R3: read request refused
        start_c();
        byte_c(8'hD7, 0, "R3");
        byte_c(8'h05, 0, "R3");
        byte_c(8'h11, 0, "R3");
        stop_c();

        // R6: burst across the wrap
        start_c();
        byte_c(8'hD6, 1, "R1");
        byte_c(8'hFE, 1, "R4");
        push_w(8'hFE, 8'h01); byte_c(8'h01, 1, "R6");
        push_w(8'hFF, 8'h02); byte_c(8'h02, 1, "R6");
        push_w(8'h00, 8'h03); byte_c(8'h03, 1, "R6");
        stop_c();

        // R7: repeated START opens a new transfer with a fresh pointer
        start_c();
        byte_c(8'hD6, 1, "R1");
        byte_c(8'h20, 1, "R4");
        push_w(8'h20, 8'h77); byte_c(8'h77, 1, "R5");
        start_c();
        byte_c(8'hD6, 1, "R7");
        byte_c(8'h40, 1, "R7");
        push_w(8'h40, 8'h88); byte_c(8'h88, 1, "R7");
        stop_c();

        // R7: STOP ends the transfer; clocking without START is ignored
        start_c();
        byte_c(8'hD6, 1, "R1");
        byte_c(8'h50, 1, "R4");
        push_w(8'h50, 8'h12); byte_c(8'h12, 1, "R5");
        stop_c();
        byte_c(8'h33, 0, "R7");
        byte_c(8'hD6, 0, "R7");
        stop_c();

        // R7: START in the middle of a byte discards the partial bits
        start_c();
        byte_c(8'hD6, 1, "R1");
        bit_c(1'b1); bit_c(1'b0); bit_c(1'b1); bit_c(1'b1);
        start_c();
        byte_c(8'hD6, 1, "R7");
        byte_c(8'h60, 1, "R7");
        push_w(8'h60, 8'h99); byte_c(8'h99, 1, "R7");
        stop_c();

        tk(40);
        chk(exp_a.size() == 0, "R5", "writes still pending", exp_a.size(), 0);
        chk(sda_oe == 1'b0, "R8", "bus released at end", sda_oe, 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule